// File: doc/BRIEF.md
# Sequential Shift-and-Add Multiplier

This block multiplies two unsigned 8-bit operands and returns a 16-bit product, producing one product bit per clock. It is split into a data unit and a four-state controller. The data unit holds the multiplicand, the upper half of the running product, and one shift register that starts out holding the multiplier and fills up with the lower product bits as it shifts right. A 9-bit sum path adds the multiplicand to the upper half whenever the bit leaving the shift register is 1.

The controller has four states. IDLE waits for a request. IDLE goes to INIT when `start` is high and stays in IDLE otherwise. INIT clears the upper half, captures both operands and clears the step counter, then always goes to RUN. RUN performs one add/shift step per clock and leaves for WAIT on its eighth cycle. WAIT shows `done` and keeps the result steady while `start` stays high. WAIT goes back to IDLE once `start` falls. The product stays on the outputs in IDLE until the next request.

A caller raises `start` with both operands valid and holds the operands until the clock edge after the request is accepted. It then waits for `done` and drops `start` to end the exchange.

Top module: `shift_add_mult`

## Requirements
- R1: While reset is high and after reset, the block is in IDLE: `idle`=1, `done`=0 and `prod_hi`=`prod_lo`=0.
- R2: In IDLE with `start` low, the block stays in IDLE and the product outputs do not change.
- R3: The clock edge after a request is accepted (INIT) captures `mpy_in` into the low/multiplier register and `mcand_in` into the multiplicand register, and clears the high register.
- R4: Exactly 8 RUN cycles take place. `done` is 0 after the 9th rising edge that follows the edge at which `start` was first seen in IDLE, and 1 after the 10th.
- R5: When `done` rises, {`prod_hi`,`prod_lo`} equals `mpy_in` × `mcand_in` as unsigned numbers, for any operand pair.
- R6: In WAIT with `start` high, `done` stays 1 and the product does not change, whatever the operand inputs do.
- R7: In WAIT with `start` low, the block returns to IDLE on the next edge (`idle`=1, `done`=0), and the product stays held.
- R8: Each new request starts from a cleared high register, so a product never builds on the previous result.
- R9: Operand inputs that change during RUN have no effect on the result.
- R10: The low/multiplier register takes a 2-bit mode: 2'b11 loads it in parallel, 2'b01 shifts it right with the sum's bit 0 entering the MSB, and 2'b00 holds it. When the clear control is set, the sum multiplexer output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request; must be held high until `done` is seen |
| mpy_in | input | 8 | Multiplier operand |
| mcand_in | input | 8 | Multiplicand operand |
| prod_hi | output | 8 | Upper 8 bits of the product |
| prod_lo | output | 8 | Lower 8 bits of the product |
| done | output | 1 | High in WAIT: the result is ready |
| idle | output | 1 | High in IDLE |

## Verification
Count the rising edges from the first edge that sees `start` in IDLE. That edge enters INIT, the next one enters RUN, and the eight RUN edges bring the block into WAIT, so `done` and the final product are due after the 10th edge. The bench checks `done` low after the 9th edge and the full result after the 10th. A falling `start` in WAIT gives `idle` after exactly one edge, and the bench looks for it there. All samples and input changes happen on the falling clock edge, away from the edge at which the registers update.

// File: rtl/mul_pkg.sv
`timescale 1ns/1ps
package mul_pkg;

    // Controller states
    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_INIT = 2'b01,
        ST_RUN  = 2'b10,
        ST_WAIT = 2'b11
    } mul_state_t;

    // Mode select for the multiplier / low-product register (R10)
    typedef enum logic [1:0] {
        MODE_HOLD = 2'b00,
        MODE_SHR  = 2'b01,
        MODE_LOAD = 2'b11
    } lp_mode_t;

    // Control bundle from the controller to the data unit
    typedef struct packed {
        logic     clr;
        logic     ld_hp;
        logic     ld_mc;
        lp_mode_t mode;
        logic     selsum;
        logic     runc;
    } mul_ctl_t;

endpackage

// File: rtl/mul_ripple_add.sv
`timescale 1ns/1ps
module mul_ripple_add #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W:0]   sum
);
    logic [W:0]   carry;
    logic [W-1:0] bits;

    assign carry[0] = 1'b0;

    // One full-adder cell per bit, chained through the carry
    for (genvar i = 0; i < W; i++) begin : g_cell
        assign bits[i]    = a[i] ^ b[i] ^ carry[i];
        assign carry[i+1] = (a[i] & b[i]) | (carry[i] & (a[i] ^ b[i]));
    end

    assign sum = {carry[W], bits};
endmodule

// File: rtl/mul_iter_cnt.sv
`timescale 1ns/1ps
module mul_iter_cnt #(
    parameter int STEPS = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic en,
    output logic last
);
    localparam int CW = $clog2(STEPS + 1);
    localparam logic [CW-1:0] LAST_VAL = CW'(STEPS - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (en) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign last = en && (cnt_q == LAST_VAL);

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST_VAL || (cnt_q == CW'(STEPS) && !en)); // R4

    AST_CNT_CLEARED: assert property (@(posedge clk) disable iff (rst)
        clr |=> cnt_q == '0); // R4
endmodule

// File: rtl/mul_ctrl.sv
`timescale 1ns/1ps
module mul_ctrl
    import mul_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       last,
    input  logic       lp_lsb,
    output mul_ctl_t   ctl,
    output mul_state_t state
);
    mul_state_t state_q, state_d;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_INIT;
            ST_INIT: state_d = ST_RUN;
            ST_RUN:  if (last) state_d = ST_WAIT;
            ST_WAIT: if (!start) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Output logic
    always_comb begin
        ctl        = '0;
        ctl.mode   = MODE_HOLD;
        unique case (state_q)
            ST_IDLE: ;
            ST_INIT: begin
                ctl.clr   = 1'b1;
                ctl.ld_hp = 1'b1;
                ctl.ld_mc = 1'b1;
                ctl.mode  = MODE_LOAD;
            end
            ST_RUN: begin
                ctl.runc   = 1'b1;
                ctl.ld_hp  = 1'b1;
                ctl.mode   = MODE_SHR;
                ctl.selsum = lp_lsb;
            end
            ST_WAIT: ;
            default: ;
        endcase
    end

    assign state = state_q;

    AST_IDLE_TO_INIT: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && start) |=> state_q == ST_INIT); // R2

    AST_IDLE_STAY: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && !start) |=> state_q == ST_IDLE); // R2

    AST_INIT_TO_RUN: assert property (@(posedge clk) disable iff (rst)
        state_q == ST_INIT |=> state_q == ST_RUN); // R3

    AST_RUN_EXIT: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN && last) |=> state_q == ST_WAIT); // R4

    AST_WAIT_EXIT: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WAIT && !start) |=> state_q == ST_IDLE); // R7
endmodule

// File: rtl/mul_datapath.sv
`timescale 1ns/1ps
module mul_datapath
    import mul_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  mul_ctl_t     ctl,
    input  logic [W-1:0] mpy_in,
    input  logic [W-1:0] mcand_in,
    output logic [W-1:0] hp,
    output logic [W-1:0] lp
);
    logic [W-1:0] mc_q, hp_q, lp_q;
    logic [W:0]   sum;
    logic [W:0]   fsel;

    mul_ripple_add #(.W(W)) u_add (
        .a   (hp_q),
        .b   (mc_q),
        .sum (sum)
    );

    // Sum multiplexer with clear gate (R10)
    always_comb begin
        if (ctl.clr) begin
            fsel = '0;
        end else if (ctl.selsum) begin
            fsel = sum;
        end else begin
            fsel = {1'b0, hp_q};
        end
    end

    // Multiplicand register
    always_ff @(posedge clk) begin
        if (rst) begin
            mc_q <= '0;
        end else if (ctl.ld_mc) begin
            mc_q <= mcand_in;
        end
    end

    // High-product register takes the upper bits of the sum path
    always_ff @(posedge clk) begin
        if (rst) begin
            hp_q <= '0;
        end else if (ctl.ld_hp) begin
            hp_q <= fsel[W:1];
        end
    end

    // Multiplier / low-product register
    always_ff @(posedge clk) begin
        if (rst) begin
            lp_q <= '0;
        end else begin
            unique case (ctl.mode)
                MODE_LOAD: lp_q <= mpy_in;
                MODE_SHR:  lp_q <= {fsel[0], lp_q[W-1:1]};
                default:   lp_q <= lp_q;
            endcase
        end
    end

    assign hp = hp_q;
    assign lp = lp_q;

    AST_INIT_LOADS: assert property (@(posedge clk) disable iff (rst)
        (ctl.clr && ctl.ld_hp && ctl.ld_mc && ctl.mode == MODE_LOAD)
        |=> (hp_q == '0 && lp_q == $past(mpy_in) && mc_q == $past(mcand_in))); // R3

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (ctl.mode == MODE_HOLD && !ctl.ld_hp && !ctl.ld_mc)
        |=> ($stable(hp_q) && $stable(lp_q) && $stable(mc_q))); // R10

    AST_SHIFT_MOVES: assert property (@(posedge clk) disable iff (rst)
        ctl.mode == MODE_SHR |=> lp_q[W-2:0] == $past(lp_q[W-1:1])); // R10

    AST_RUN_MC_STABLE: assert property (@(posedge clk) disable iff (rst)
        ctl.runc |=> $stable(mc_q)); // R9
endmodule

// File: rtl/shift_add_mult.sv
`timescale 1ns/1ps
module shift_add_mult
    import mul_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] mpy_in,
    input  logic [W-1:0] mcand_in,
    output logic [W-1:0] prod_hi,
    output logic [W-1:0] prod_lo,
    output logic         done,
    output logic         idle
);
    mul_ctl_t   ctl;
    mul_state_t state;
    logic       last;
    logic [W-1:0] hp, lp;

    mul_ctrl u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .last   (last),
        .lp_lsb (lp[0]),
        .ctl    (ctl),
        .state  (state)
    );

    mul_iter_cnt #(.STEPS(W)) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .clr  (ctl.clr),
        .en   (ctl.runc),
        .last (last)
    );

    mul_datapath #(.W(W)) u_dp (
        .clk      (clk),
        .rst      (rst),
        .ctl      (ctl),
        .mpy_in   (mpy_in),
        .mcand_in (mcand_in),
        .hp       (hp),
        .lp       (lp)
    );

    assign prod_hi = hp;
    assign prod_lo = lp;
    assign done    = (state == ST_WAIT);
    assign idle    = (state == ST_IDLE);

    AST_ONE_STATUS: assert property (@(posedge clk) disable iff (rst)
        !(done && idle)); // R1

    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (done && start) |=> (done && $stable(prod_hi) && $stable(prod_lo))); // R6

    AST_IDLE_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (idle && !start) |=> ($stable(prod_hi) && $stable(prod_lo))); // R2
endmodule

// File: tb/sim_shift_add_mult.sv
`timescale 1ns/1ps
module sim_shift_add_mult;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [7:0] mpy_in = '0;
    logic [7:0] mcand_in = '0;
    logic [7:0] prod_hi, prod_lo;
    logic       done, idle;

    int n_checks = 0;
    int n_errors = 0;

    shift_add_mult u0 (
        .clk(clk), .rst(rst), .start(start), .mpy_in(mpy_in), .mcand_in(mcand_in),
        .prod_hi(prod_hi), .prod_lo(prod_lo), .done(done), .idle(idle)
    );

    always #4 clk = ~clk;   // 125 MHz

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 idle", 32'(idle), 1);
        check("R1 done", 32'(done), 0);
        check("R1 product", 32'({prod_hi, prod_lo}), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 idle after release", 32'(idle), 1);
    endtask

    task automatic t_no_start(input logic [15:0] held);
        @(negedge clk);
        mpy_in = 8'h5a; mcand_in = 8'hc3; start = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check("R2 stays idle", 32'(idle), 1);
        check("R2 product unchanged", 32'({prod_hi, prod_lo}), 32'(held));
    endtask

    // One full exchange; disturb changes operands in the middle of RUN (R9)
    task automatic t_mult(input logic [7:0] a, input logic [7:0] b, input bit disturb, input bit full);
        logic [15:0] exp_p;
        exp_p = 16'(a) * 16'(b);
        @(negedge clk);
        mpy_in = a; mcand_in = b; start = 1'b1;
        repeat (2) @(posedge clk);     // IDLE->INIT, INIT->RUN (operands captured)
        @(negedge clk);
        mpy_in = ~a; mcand_in = a ^ b ^ 8'h3c;   // R3: captured values must survive
        repeat (2) @(posedge clk);
        if (disturb) begin
            @(negedge clk);
            mpy_in = b; mcand_in = a + 8'd1;    // R9
        end
        repeat (5) @(posedge clk);
        @(negedge clk);
        check("R4 done low after 9 edges", 32'(done), 0);
        @(posedge clk);
        @(negedge clk);
        check("R4 done after 10 edges", 32'(done), 1);
        if (disturb)
            check("R9 product despite operand change", 32'({prod_hi, prod_lo}), 32'(exp_p));
        else
            check("R5 product", 32'({prod_hi, prod_lo}), 32'(exp_p));
        if (full) begin
            mpy_in = 8'hff; mcand_in = 8'hff;
            repeat (3) @(posedge clk);
            @(negedge clk);
            check("R6 done held", 32'(done), 1);
            check("R6 product held", 32'({prod_hi, prod_lo}), 32'(exp_p));
        end
        start = 1'b0;
        @(posedge clk);
        @(negedge clk);
        if (full) begin
            check("R7 idle after release", 32'(idle), 1);
            check("R7 done cleared", 32'(done), 0);
            check("R7 product kept", 32'({prod_hi, prod_lo}), 32'(exp_p));
        end
    endtask

    task automatic t_back_to_back;
        t_mult(8'hff, 8'hff, 1'b0, 1'b1);
        t_mult(8'h00, 8'h00, 1'b0, 1'b0);
        check("R8 fresh product after large one", 32'({prod_hi, prod_lo}), 0);
        t_mult(8'h01, 8'h01, 1'b0, 1'b0);
        check("R8 unit product", 32'({prod_hi, prod_lo}), 1);
    endtask

    task automatic t_corners;
        t_mult(8'h00, 8'hff, 1'b0, 1'b1);
        t_mult(8'hff, 8'h01, 1'b0, 1'b0);
        t_mult(8'h01, 8'hff, 1'b0, 1'b0);
        t_mult(8'h80, 8'h02, 1'b0, 1'b0);
        t_mult(8'haa, 8'h55, 1'b0, 1'b1);
        t_mult(8'h80, 8'h80, 1'b0, 1'b0);
        t_mult(8'h7f, 8'hfe, 1'b1, 1'b0);
    endtask

    // R10: bit-0 of the sum enters the low register MSB; patterns with one set bit walk it
    task automatic t_shift_pattern;
        for (int k = 0; k < 8; k++) begin
            t_mult(8'(1 << k), 8'hff, 1'b0, 1'b0);
            check("R10 shift pattern", 32'({prod_hi, prod_lo}), 32'(16'hff << k));
        end
    endtask

    task automatic t_sweep;
        logic [15:0] lf;
        lf = 16'hace1;
        for (int n = 0; n < 300; n++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            t_mult(lf[15:8], lf[7:0], (n % 7) == 3, 1'b0);
        end
    endtask

    initial begin
        #1_000_000;
        n_errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    initial begin
        t_reset();
        t_no_start(16'h0000);
        t_corners();
        t_no_start(16'h7fff & 16'(16'h7f * 16'hfe));
        t_back_to_back();
        t_shift_pattern();
        t_sweep();
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end
endmodule